// File: doc/BRIEF.md
# Chainable Highest-Index Request Encoder

This block turns a set of request lines into the binary number of the most important one, where importance rises with the line number. It is purely combinational. A single lane covers eight requests and carries three flags for chaining: an enable coming in, a "hit" flag that says the lane found something, and a "pass" flag that says the lane was enabled but found nothing. A lane only responds while its enable is high, so a less important lane can be placed behind it.

The top level joins two such lanes into a sixteen-request encoder. The lane holding requests 15..8 is enabled by the top's enable. Its pass flag enables the lane holding requests 7..0. The top code's most significant bit shows which lane produced the result. The low bits are the OR of both lanes' codes, and only one lane can hold a non-zero code at a time.

Top module: `prio_chain`

## Requirements
- R1: With en_in high, idx equals the number of the highest-numbered set bit of req; higher numbers always win over lower ones.
- R2: With en_in low, idx is 0 and hit and pass are both 0, whatever req holds.
- R3: hit is 1 exactly when en_in is high and at least one req bit is set.
- R4: pass is 1 exactly when en_in is high and req is all zeros.
- R5: With en_in high and exactly one req bit set at position k, idx equals k, as a plain binary encoder would give.
- R6: req equal to 1 and req equal to 0 both give idx 0 when enabled; hit is 1 for the first and 0 for the second.
- R7: idx bit 3 is 1 exactly when en_in is high and any of req[15:8] is set; the low three bits then give the position within that upper group.
- R8: When any of req[15:8] is set, the bits req[7:0] have no effect on idx, hit or pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_in | input | 1 | Enable; high lets the encoder respond to requests |
| req | input | 16 | Request lines, bit 15 most important |
| idx | output | 4 | Binary number of the winning request |
| hit | output | 1 | Enabled and at least one request present |
| pass | output | 1 | Enabled and no request present; enables a following stage |

## Verification
The immediate assertions watch each lane on every input change. They check that a disabled lane stays silent, that hit and pass never rise together, that at most one candidate bit wins, that the chosen code points at a set request, and that the top's upper code bit follows the upper request group. Only the bench's scenarios can show that the chosen index is the highest one, that lower requests are masked behind upper ones, and that request 0 alone differs from no request only in hit. The bench compares all 65536 request patterns with the encoder enabled against a separate highest-bit model, and also applies a set of patterns with the encoder disabled.

// File: rtl/prio_pkg.sv
package prio_pkg;

  parameter int DEF_LANE = 8;

  typedef struct packed {
    logic hit;
    logic pass;
  } lane_flag_t;

endpackage

// File: rtl/prio_lane.sv
module prio_lane #(
  parameter int N = prio_pkg::DEF_LANE,
  localparam int W = $clog2(N)
) (
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [W-1:0] idx_o,
  output logic         hit_o,
  output logic         pass_o
);

  logic [N-1:0] win;
  logic [W-1:0] raw_idx;
  logic         any_req;

  // a bit wins when it is set and nothing above it is set
  for (genvar i = 0; i < N; i++) begin : g_win
    if (i == N - 1) begin : g_top
      assign win[i] = req_i[i];
    end else begin : g_rest
      assign win[i] = req_i[i] & ~(|req_i[N-1:i+1]);
    end
  end

  always_comb begin
    raw_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) raw_idx = raw_idx | W'(i);
    end
  end

  assign any_req = |req_i;
  assign idx_o   = en_i ? raw_idx : '0;
  assign hit_o   = en_i & any_req;
  assign pass_o  = en_i & ~any_req;

  always_comb begin
    p_quiet_off_r2: assert (en_i || (idx_o == '0 && !hit_o && !pass_o))
      else $error("disabled lane not silent");
    p_flags_excl_r3: assert (!(hit_o && pass_o))
      else $error("hit and pass together");
    p_one_winner_r1: assert ($onehot0(win))
      else $error("more than one winning bit");
    p_code_points_r1: assert (!hit_o || req_i[idx_o])
      else $error("code points at idle request");
    p_empty_pass_r4: assert (!(en_i && req_i == '0) || pass_o)
      else $error("empty enabled lane without pass");
  end

endmodule

// File: rtl/prio_chain.sv
module prio_chain
  import prio_pkg::*;
#(
  parameter int LANE = DEF_LANE,
  localparam int TOTAL = 2 * LANE,
  localparam int LW = $clog2(LANE)
) (
  input  logic             en_in,
  input  logic [TOTAL-1:0] req,
  output logic [LW:0]      idx,
  output logic             hit,
  output logic             pass
);

  logic [LW-1:0] up_idx, lo_idx;
  lane_flag_t    up_f, lo_f;

  prio_lane #(.N(LANE)) u_upper (
    .en_i   (en_in),
    .req_i  (req[TOTAL-1:LANE]),
    .idx_o  (up_idx),
    .hit_o  (up_f.hit),
    .pass_o (up_f.pass)
  );

  // lower lane only listens when the upper one found nothing
  prio_lane #(.N(LANE)) u_lower (
    .en_i   (up_f.pass),
    .req_i  (req[LANE-1:0]),
    .idx_o  (lo_idx),
    .hit_o  (lo_f.hit),
    .pass_o (lo_f.pass)
  );

  assign idx  = {up_f.hit, up_idx | lo_idx};
  assign hit  = up_f.hit | lo_f.hit;
  assign pass = lo_f.pass;

  always_comb begin
    p_upper_msb_r7: assert (idx[LW] == (en_in && (|req[TOTAL-1:LANE])))
      else $error("upper group bit wrong");
    p_lower_masked_r8: assert (!up_f.hit || (!lo_f.hit && lo_idx == '0))
      else $error("lower lane active behind upper hit");
  end

endmodule

// File: tb/prio_chain_test.sv
module prio_chain_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_in = 1'b0;
  logic [15:0] req = '0;
  logic [3:0]  idx;
  logic        hit, pass;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [3:0] idx;
    logic       hit;
    logic       pass;
    string      tag;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;

  prio_chain uut (
    .en_in (en_in),
    .req   (req),
    .idx   (idx),
    .hit   (hit),
    .pass  (pass)
  );

  function automatic item_t model(input logic e, input logic [15:0] r);
    item_t it;
    it.idx = '0;
    it.hit = 1'b0;
    it.pass = 1'b0;
    if (e) begin
      for (int b = 0; b < 16; b++) if (r[b]) it.idx = 4'(b);
      it.hit  = (r != 0);
      it.pass = (r == 0);
    end
    if (!e)                                 it.tag = "R2";
    else if (r == 0 || r == 1)              it.tag = "R6";
    else if ($countones(r) == 1)            it.tag = "R5";
    else if (r[15:8] != 0 && r[7:0] != 0)   it.tag = "R8";
    else if (r[15:8] != 0)                  it.tag = "R7";
    else                                    it.tag = "R1";
    return it;
  endfunction

  task automatic apply(input logic e, input logic [15:0] r);
    @(posedge clk);
    en_in = e;
    req   = r;
    sb.push_back(model(e, r));
  endtask

  // monitor: compare half a cycle after each drive
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t exp;
      exp = sb.pop_front();
      checks++;
      if (idx !== exp.idx) begin
        fails++;
        $display("FAIL %s idx: en=%b req=%h actual=%0d expected=%0d",
                 exp.tag, en_in, req, idx, exp.idx);
      end
      checks++;
      if (hit !== exp.hit) begin
        fails++;
        $display("FAIL %s hit: en=%b req=%h actual=%b expected=%b",
                 (exp.tag == "R2") ? "R2" : "R3", en_in, req, hit, exp.hit);
      end
      checks++;
      if (pass !== exp.pass) begin
        fails++;
        $display("FAIL %s pass: en=%b req=%h actual=%b expected=%b",
                 (exp.tag == "R2") ? "R2" : "R4", en_in, req, pass, exp.pass);
      end
    end
  end

  initial begin
    fork
      begin
        // reset state: disabled, no requests (R2)
        sb.push_back(model(1'b0, 16'h0000));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // disabled with many patterns: requests ignored (R2)
        for (int k = 0; k < 64; k++) apply(1'b0, 16'(k * 1031 + 7));
        apply(1'b0, 16'hFFFF);
        // R6: request 0 alone versus none
        apply(1'b1, 16'h0001);
        apply(1'b1, 16'h0000);
        // R5: each single request
        for (int k = 0; k < 16; k++) apply(1'b1, 16'(1 << k));
        // R8: lower noise behind an upper request
        apply(1'b1, 16'h01FF);
        apply(1'b1, 16'h80FF);
        // R1, R7: exhaustive sweep
        for (int k = 0; k < 65536; k++) apply(1'b1, 16'(k));
        @(posedge clk);
        @(posedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule